// File: doc/BRIEF.md
# Vectored Countdown Interrupt Timer

This block is a per-processor countdown timer that feeds an interrupt controller. Software loads a start value, picks a prescale ratio and programs an entry that holds the interrupt vector, a mask bit and a repeat bit. The counter then steps down once per prescaled tick. When a countdown runs out, the block sends a one-cycle interrupt request that carries the programmed vector. Prioritising that request is the job of the logic that receives it.

The block has two modes. In single-shot mode the count runs down to zero, stays there, and the request fires once. In repeating mode the count reloads from the start value after it reaches zero, so it fires every start value + 1 ticks. Register access uses a plain write strobe with a 2-bit select. Reads are combinational.

Top module: `lvt_timer_top`

## Requirements
- R1: The prescale register (select 3) keeps only bits 3, 1 and 0 of a write. Reading it returns the written value ANDed with 0xB.
- R2: The prescale ratio is 2^((code+1) mod 8), where code = {cfg[3], cfg[1], cfg[0]}. Code 7 gives a ratio of 1, and codes 0 to 6 give ratios 2 to 128.
- R3: The entry register (select 0) holds the vector in bits 7:0, the mask in bit 16 and the repeat bit in bit 17. All other bits read as zero.
- R4: A write to the start-value register (select 1) loads the current count (select 2, read-only) and restarts the prescaler. After that the count falls by one per prescaled tick.
- R5: In single-shot mode with start value W>0 and ratio d, the request fires (W+1)*d clock cycles after the load. The count then stays at zero and no further request follows.
- R6: In repeating mode the count reloads from the start value after zero, and the request fires once every (W+1)*d cycles.
- R7: A start value of zero never produces a request, in either mode.
- R8: While the mask bit is set, no request is raised, but counting and reloading carry on.
- R9: After reset the entry reads 0x0001_0000, the start value, current count and prescale register read zero, and no request is active.
- R10: Writing the entry register does not change the current count. Unmasking lets the next expiry fire without a reload.
- R11: The request is a single-cycle valid pulse. The vector output shows the entry's vector from the cycle of expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 entry, 1 start value, 2 current count, 3 prescale |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_sel |
| irq_valid | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector carried with the request |

## Verification
A prescaler that slips or divides by the wrong ratio shows up as a wrong request latency on the first expiry after a load, at (W+1)*d cycles. Each prescale code therefore has a separate latency measurement. A corrupt count or a broken reload shows on the current-count readback within one tick, or as a changed period by the second repeating expiry. A stale single-shot arm or a mask leak shows as an extra request in the quiet window after the expected one.

// File: rtl/lvt_timer_pkg.sv
package lvt_timer_pkg;
  typedef enum logic [1:0] {
    SEL_ENTRY = 2'd0,
    SEL_START = 2'd1,
    SEL_COUNT = 2'd2,
    SEL_PRESC = 2'd3
  } reg_sel_e;

  localparam int REPEAT_BIT = 17;
  localparam int MASK_BIT   = 16;
  localparam logic [3:0] PRESC_KEEP = 4'b1011;

  function automatic logic [2:0] presc_shift(input logic [3:0] cfg);
    logic [2:0] code;
    code = {cfg[3], cfg[1:0]};
    return code + 3'd1;
  endfunction
endpackage

// File: rtl/lvt_timer_prescaler.sv
module lvt_timer_prescaler #(
  parameter int SHIFT_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic [SHIFT_W-1:0] shift,
  output logic               tick
);
  localparam int PW = (1 << SHIFT_W) - 1;

  logic [PW-1:0] cnt_q, cnt_d, limit;
  logic [PW:0]   span;

  always_comb begin
    span  = (PW+1)'(1) << shift;
    limit = PW'(span - (PW+1)'(1));
    tick  = !restart && (cnt_q == limit);
    if (restart || tick) cnt_d = '0;
    else                 cnt_d = cnt_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/lvt_timer_downcount.sv
module lvt_timer_downcount #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] start_val,
  input  logic             tick,
  input  logic             repeat_mode,
  output logic             expire,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             armed_q, armed_d;

  always_comb begin
    cnt_d   = cnt_q;
    armed_d = armed_q;
    expire  = 1'b0;
    if (load) begin
      cnt_d   = load_val;
      armed_d = (load_val != '0);
    end else if (tick) begin
      if (cnt_q != '0) begin
        cnt_d = cnt_q - CNT_W'(1);
      end else if (repeat_mode) begin
        if (start_val != '0) begin
          cnt_d  = start_val;
          expire = 1'b1;
        end
      end else if (armed_q) begin
        expire  = 1'b1;
        armed_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
    end
  end

  assign count = cnt_q;
endmodule

// File: rtl/lvt_timer_top.sv
module lvt_timer_top #(
  parameter int CNT_W  = 32,
  parameter int VEC_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_valid,
  output logic [VEC_W-1:0]  irq_vector
);
  import lvt_timer_pkg::*;

  localparam int SHIFT_W = 3;

  logic             repeat_q, mask_q, repeat_d, mask_d;
  logic [VEC_W-1:0] vec_q, vec_d, irqv_q, irqv_d;
  logic [CNT_W-1:0] start_q, start_d, count;
  logic [3:0]       presc_q, presc_d;
  logic             irq_q, irq_d;
  logic             wr_entry, wr_start, wr_presc, tick, expire;
  logic [SHIFT_W-1:0] shift;

  assign wr_entry = reg_we && (reg_sel == SEL_ENTRY);
  assign wr_start = reg_we && (reg_sel == SEL_START);
  assign wr_presc = reg_we && (reg_sel == SEL_PRESC);
  assign shift    = presc_shift(presc_q);

  lvt_timer_prescaler #(.SHIFT_W(SHIFT_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .restart(wr_start), .shift(shift), .tick(tick)
  );

  lvt_timer_downcount #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .load(wr_start), .load_val(reg_wdata[CNT_W-1:0]),
    .start_val(start_q), .tick(tick), .repeat_mode(repeat_q),
    .expire(expire), .count(count)
  );

  always_comb begin
    repeat_d = repeat_q;
    mask_d   = mask_q;
    vec_d    = vec_q;
    start_d  = start_q;
    presc_d  = presc_q;
    if (wr_entry) begin
      repeat_d = reg_wdata[REPEAT_BIT];
      mask_d   = reg_wdata[MASK_BIT];
      vec_d    = reg_wdata[VEC_W-1:0];
    end
    if (wr_start) start_d = reg_wdata[CNT_W-1:0];
    if (wr_presc) presc_d = reg_wdata[3:0] & PRESC_KEEP;
    irq_d  = expire && !mask_q;
    irqv_d = expire ? vec_q : irqv_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      repeat_q <= 1'b0;
      mask_q   <= 1'b1;
      vec_q    <= '0;
      start_q  <= '0;
      presc_q  <= '0;
      irq_q    <= 1'b0;
      irqv_q   <= '0;
    end else begin
      repeat_q <= repeat_d;
      mask_q   <= mask_d;
      vec_q    <= vec_d;
      start_q  <= start_d;
      presc_q  <= presc_d;
      irq_q    <= irq_d;
      irqv_q   <= irqv_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_sel)
      SEL_ENTRY: begin
        reg_rdata[REPEAT_BIT] = repeat_q;
        reg_rdata[MASK_BIT]   = mask_q;
        reg_rdata[VEC_W-1:0]  = vec_q;
      end
      SEL_START: reg_rdata[CNT_W-1:0] = start_q;
      SEL_COUNT: reg_rdata[CNT_W-1:0] = count;
      default:   reg_rdata[3:0] = presc_q;
    endcase
  end

  assign irq_valid  = irq_q;
  assign irq_vector = irqv_q;
endmodule

// File: rtl/lvt_timer_chk.sv
module lvt_timer_chk #(
  parameter int CNT_W = 32,
  parameter int VEC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_start,
  input logic             wr_entry,
  input logic             repeat_q,
  input logic             mask_q,
  input logic [VEC_W-1:0] vec_q,
  input logic [CNT_W-1:0] start_q,
  input logic [CNT_W-1:0] count,
  input logic             irq_valid,
  input logic [VEC_W-1:0] irq_vector
);
  assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_start && count != '0) |=> (count == $past(count) || count == $past(count) - CNT_W'(1)));

  assert_single_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_start && count == '0 && !repeat_q) |=> (count == '0));

  assert_zero_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> !($past(repeat_q) && $past(start_q) == '0));

  assert_masked_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> !$past(mask_q));

  assert_vector_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_vector == $past(vec_q)));

  assert_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !$past(wr_entry)) |=> !irq_valid);
endmodule

bind lvt_timer_top lvt_timer_chk #(.CNT_W(CNT_W), .VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_entry(wr_entry),
  .repeat_q(repeat_q), .mask_q(mask_q), .vec_q(vec_q), .start_q(start_q),
  .count(count), .irq_valid(irq_valid), .irq_vector(irq_vector)
);

// File: tb/tb_lvt_timer_top.sv
module tb_lvt_timer_top;
  logic        clk, rst_n, reg_we;
  logic [1:0]  reg_sel;
  logic [31:0] reg_wdata, reg_rdata;
  logic        irq_valid;
  logic [7:0]  irq_vector;
  int checks = 0, fails = 0;
  bit done = 0;

  lvt_timer_top dut (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_valid(irq_valid),
    .irq_vector(irq_vector));

  initial clk = 0;
  always #4 clk = ~clk;

  // {prescale cfg, start value, vector}
  localparam logic [43:0] VECS [9] = '{
    {4'hB, 32'd5, 8'h31}, {4'h0, 32'd3, 8'h42}, {4'h1, 32'd2, 8'h53},
    {4'h2, 32'd1, 8'h64}, {4'h3, 32'd2, 8'h75}, {4'h8, 32'd1, 8'h86},
    {4'h9, 32'd1, 8'h97}, {4'hA, 32'd2, 8'hA8}, {4'hF, 32'd4, 8'hB9}};

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    reg_we = 1; reg_sel = s; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] d);
    reg_sel = s; #1; d = reg_rdata;
  endtask

  task automatic wait_irq(output int n);
    n = 0;
    do begin
      @(posedge clk); n++; @(negedge clk);
    end while (!irq_valid && n < 5000);
  endtask

  task automatic count_irqs(input int cyc, output int k);
    k = 0;
    for (int i = 0; i < cyc; i++) begin
      @(posedge clk); @(negedge clk);
      if (irq_valid) k++;
    end
  endtask

  function automatic int ratio(input logic [3:0] c);
    int code;
    code = {c[3], c[1], c[0]};
    return 1 << ((code + 1) % 8);
  endfunction

  initial begin
    #1500000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    int n, k;
    rst_n = 0; reg_we = 0; reg_sel = 0; reg_wdata = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(negedge clk);

    // R9 reset state
    rd(2'd0, r); check("R9 entry", r, 32'h0001_0000);
    rd(2'd1, r); check("R9 start", r, 0);
    rd(2'd2, r); check("R9 count", r, 0);
    rd(2'd3, r); check("R9 presc", r, 0);
    check("R9 irq", {31'd0, irq_valid}, 0);

    // Table: R2 ratio, R5 single-shot latency and hold, R11 vector
    for (int v = 0; v < 9; v++) begin
      logic [3:0] c; logic [31:0] w; logic [7:0] vec; int exp;
      {c, w, vec} = VECS[v];
      exp = (int'(w) + 1) * ratio(c);
      wr(2'd3, {28'd0, c});
      wr(2'd0, {24'd0, vec});
      wr(2'd1, w);
      wait_irq(n);
      check("R2 R5 latency", n, exp);
      check("R11 vector", {24'd0, irq_vector}, {24'd0, vec});
      @(posedge clk); @(negedge clk);
      check("R11 pulse width", {31'd0, irq_valid}, 0);
      rd(2'd2, r); check("R5 count held", r, 0);
      count_irqs(2 * exp, k);
      check("R5 single fire", k, 0);
    end

    // R1 prescale masking
    wr(2'd3, 32'hFFFF_FFFF); rd(2'd3, r); check("R1 presc mask", r, 32'hB);
    wr(2'd3, 32'h0000_0004); rd(2'd3, r); check("R1 bit2 dropped", r, 0);

    // R3 entry fields
    wr(2'd0, 32'hFFFF_FFFF); rd(2'd0, r); check("R3 entry fields", r, 32'h0003_00FF);

    // R4 load and restart
    wr(2'd3, 32'hB); wr(2'd0, 32'h20);
    wr(2'd1, 32'd10); rd(2'd2, r); check("R4 load", r, 10);
    repeat (3) begin @(posedge clk); @(negedge clk); end
    rd(2'd2, r); check("R4 step", r, 7);
    wr(2'd1, 32'd10);
    wait_irq(n); check("R4 restart latency", n, 11);

    // R10 entry write keeps count
    wr(2'd3, 32'hA); wr(2'd1, 32'd50);
    repeat (5) begin @(posedge clk); @(negedge clk); end
    wr(2'd0, 32'h0001_0033);
    rd(2'd2, r); check("R10 count kept", r, 50);

    // R6 repeating
    wr(2'd3, 32'hB); wr(2'd0, 32'h0002_0077); wr(2'd1, 32'd4);
    wait_irq(n); check("R6 first period", n, 5);
    check("R11 repeat vector", {24'd0, irq_vector}, 32'h77);
    wait_irq(n); check("R6 second period", n, 5);
    wait_irq(n); check("R6 third period", n, 5);
    count_irqs(50, k); check("R6 fires per period", k, 10);

    // R7 zero start value
    wr(2'd1, 32'd0); count_irqs(100, k); check("R7 repeat zero", k, 0);
    wr(2'd0, 32'h77); wr(2'd1, 32'd0); count_irqs(100, k); check("R7 single zero", k, 0);

    // R8 masked
    wr(2'd0, 32'h0001_0055); wr(2'd1, 32'd6);
    count_irqs(30, k); check("R8 masked single", k, 0);
    rd(2'd2, r); check("R8 counting continues", r, 0);
    wr(2'd0, 32'h0003_0055); wr(2'd1, 32'd3);
    count_irqs(40, k); check("R8 masked repeat", k, 0);
    wr(2'd0, 32'h0002_0055);
    count_irqs(40, k); check("R10 unmask no reload", k, 10);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule